// File: doc/BRIEF.md
# Three-Level Interrupt Priority Controller

This block decides which interrupt request a small 8-bit CPU core should take next. Each cycle it looks at the event flags from several timers, a port wakeup source and a group of miscellaneous sources that share one entry point. It also looks at a debug request that cannot be masked. It presents the winner to the CPU as a registered request strobe, with the winner's interrupt number, priority level and vector address.

Ordinary sources are filtered by their own enable bit and by a global enable. Each one is then placed on level 0 or level 1 by its own priority bit. The debug request always runs on level 2. Within one level, the source with the lower interrupt number wins. The controller keeps a record of which levels are being serviced, using the CPU's acknowledge and return pulses. A request is only issued when it is strictly above every active level. After each return, the controller waits until the CPU reports one completed instruction before it issues another request.

The enable and priority bits are held in two 8-bit registers. These are reached through a simple write/read port.

Top module: `ipc_ctrl`

## Requirements
- R1: An ordinary slot can produce a request only when its bit in the enable register (address 0, bit = slot index) and the global enable bit (address 0, bit 7) are both 1. When the global bit is 0, no ordinary slot is requested.
- R2: The debug request is issued on level 2 with interrupt number 15, whatever the enable register holds.
- R3: Each ordinary slot runs on level 1 when its bit in the level register (address 1, bit = slot index) is 1, and on level 0 otherwise. A pending level-1 slot wins over any level-0 slot.
- R4: Among requests on the same level, the lowest interrupt number wins. The slot numbers are: timers 0..3 → 1..4 (slots 0..3), port wakeup → 12 (slot 4), shared group → 14 (slot 5).
- R5: Any bit of the shared group flag input raises slot 5. That slot uses one enable bit and one level bit.
- R6: A flag present before a clock edge produces the request strobe right after that edge. The vector output is 0x0003 + 8 × number.
- R7: No request is issued while a level equal to or above the candidate's level is in service. A candidate on a strictly higher level is issued.
- R8: After a return pulse, no request is issued until the cycle after the CPU has reported one completed instruction.
- R9: An acknowledge while the strobe is high marks the presented level as in service and drops the strobe on the next cycle. A return clears the highest level in service. After reset no request is present.
- R10: Register reads return the written enable and level bits. Unused bit positions read as 0. Both registers reset to 0.
- R11: When the base select input is 1, 0x4000 is added to the vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_flag_i | input | 5 | Event flags of timers 0..3 and the port wakeup |
| grp_flag_i | input | 5 | Event flags of the sources sharing slot 5 |
| dbg_req_i | input | 1 | Debug request, non-maskable, level 2 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 enable, 1 level |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data of the selected register |
| vec_base_sel_i | input | 1 | Selects the vector table at 0x4000 |
| ack_i | input | 1 | CPU accepts the presented request |
| reti_i | input | 1 | CPU executes a return from interrupt |
| instr_done_i | input | 1 | CPU completed one instruction |
| irq_req_o | output | 1 | Request strobe to the CPU |
| irq_level_o | output | 2 | Level of the presented request |
| irq_num_o | output | 4 | Interrupt number of the presented request |
| irq_vec_o | output | 16 | Vector address of the presented request |

## Verification
The bench builds the controller with its default parameters: four timers, a five-member shared group, port number 12, group number 14 and debug number 15. With these values all six ordinary slots and the debug source can be driven. This covers the full same-level ordering, level-1 slots winning over level-0 slots, and debug winning over both. Nesting is followed through two stacked active levels. The bench then checks that each return clears only the top one, and that the one-instruction wait holds even when a blocked request is still pending.

// File: rtl/ipc_pkg.sv
// Shared types and helper functions for the interrupt priority controller.
// Assumes interrupt numbers fit in 4 bits and vectors in 16 bits.
package ipc_pkg;

    typedef logic [1:0] lvl_t;

    localparam lvl_t LVL_LO  = 2'd0;
    localparam lvl_t LVL_HI  = 2'd1;
    localparam lvl_t LVL_DBG = 2'd2;

    // Interrupt number of ordinary slot idx: timers first, then port, then group.
    function automatic int slot_number(int idx, int n_tmr, int port_num, int grp_num);
        if (idx < n_tmr)
            return idx + 1;
        else if (idx == n_tmr)
            return port_num;
        else
            return grp_num;
    endfunction

endpackage

// File: rtl/ipc_regs.sv
// Enable and level registers behind a one-bit-address write/read port.
// Address 0: bit DW-1 global enable, bits NSLOT-1..0 slot enables.
// Address 1: bits NSLOT-1..0 slot level bits. Unused bits read 0.
// Assumes NSLOT <= DW-2.
module ipc_regs #(
    parameter int DW    = 8,
    parameter int NSLOT = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic             addr_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o,
    output logic [NSLOT-1:0] en_o,
    output logic             glb_o,
    output logic [NSLOT-1:0] prio_o
);

    localparam int PAD = DW - NSLOT;

    logic [NSLOT-1:0] en_q;
    logic [NSLOT-1:0] prio_q;
    logic             glb_q;
    logic             unused_wbits;

    assign unused_wbits = ^wdata_i[DW-2:NSLOT];

    // Register update on writes; synchronous reset clears everything.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            prio_q <= '0;
            glb_q  <= 1'b0;
        end else if (we_i) begin
            if (!addr_i) begin
                en_q  <= wdata_i[NSLOT-1:0];
                glb_q <= wdata_i[DW-1];
            end else begin
                prio_q <= wdata_i[NSLOT-1:0];
            end
        end
    end

    // Read multiplexer, unused positions forced to zero.
    always_comb begin
        if (!addr_i)
            rdata_o = {glb_q, {(PAD-1){1'b0}}, en_q};
        else
            rdata_o = {{PAD{1'b0}}, prio_q};
    end

    assign en_o   = en_q;
    assign glb_o  = glb_q;
    assign prio_o = prio_q;

endmodule

// File: rtl/ipc_arbiter.sv
// Combinational selection of the winning request. The debug source wins on
// level 2. Otherwise the lowest-index qualified slot on level 1 wins, then
// the lowest-index slot on level 0. Slot index order equals interrupt
// number order.
module ipc_arbiter
    import ipc_pkg::*;
#(
    parameter int NSLOT    = 6,
    parameter int NUM_TMR  = 4,
    parameter int PORT_NUM = 12,
    parameter int GRP_NUM  = 14,
    parameter int DBG_NUM  = 15,
    parameter int NUM_W    = 4
) (
    input  logic [NSLOT-1:0] pend_i,
    input  logic [NSLOT-1:0] en_i,
    input  logic             glb_i,
    input  logic [NSLOT-1:0] prio_i,
    input  logic             dbg_i,
    output logic             win_vld_o,
    output lvl_t             win_lvl_o,
    output logic [NUM_W-1:0] win_num_o
);

    logic [NSLOT-1:0] qual;
    logic [NUM_W-1:0] slot_num [NSLOT];

    // Per-slot qualification and constant number table.
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        assign qual[g]     = pend_i[g] & en_i[g] & glb_i;
        assign slot_num[g] = NUM_W'(slot_number(g, NUM_TMR, PORT_NUM, GRP_NUM));
    end

    // Priority scan: descending loop so that the lowest index is kept.
    always_comb begin
        logic             hi_hit;
        logic             lo_hit;
        logic [NUM_W-1:0] hi_num;
        logic [NUM_W-1:0] lo_num;
        hi_hit = 1'b0;
        lo_hit = 1'b0;
        hi_num = '0;
        lo_num = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (qual[i] && prio_i[i]) begin
                hi_hit = 1'b1;
                hi_num = slot_num[i];
            end
            if (qual[i] && !prio_i[i]) begin
                lo_hit = 1'b1;
                lo_num = slot_num[i];
            end
        end
        if (dbg_i) begin
            win_vld_o = 1'b1;
            win_lvl_o = LVL_DBG;
            win_num_o = NUM_W'(DBG_NUM);
        end else if (hi_hit) begin
            win_vld_o = 1'b1;
            win_lvl_o = LVL_HI;
            win_num_o = hi_num;
        end else begin
            win_vld_o = lo_hit;
            win_lvl_o = LVL_LO;
            win_num_o = lo_num;
        end
    end

endmodule

// File: rtl/ipc_service.sv
// In-service level tracking and issue gating. Acknowledge of a presented
// request sets its level bit; return clears the highest set bit and arms a
// hold that lasts until the CPU reports one completed instruction.
module ipc_service
    import ipc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ack_i,
    input  logic       reti_i,
    input  logic       done_i,
    input  logic       req_i,
    input  lvl_t       grant_lvl_i,
    input  logic       cand_vld_i,
    input  lvl_t       cand_lvl_i,
    output logic       issue_o,
    output logic [2:0] isr_o
);

    logic [2:0] isr_q;
    logic [2:0] isr_d;
    logic       hold_q;
    logic       blocked;

    // Next in-service state: clear the top bit on return, then set on acknowledge.
    always_comb begin
        isr_d = isr_q;
        if (reti_i) begin
            if (isr_q[2])      isr_d[2] = 1'b0;
            else if (isr_q[1]) isr_d[1] = 1'b0;
            else               isr_d[0] = 1'b0;
        end
        if (ack_i && req_i)
            isr_d[grant_lvl_i] = 1'b1;
    end

    // State registers for in-service bits and the post-return hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q  <= '0;
            hold_q <= 1'b0;
        end else begin
            isr_q <= isr_d;
            if (reti_i)
                hold_q <= 1'b1;
            else if (done_i)
                hold_q <= 1'b0;
        end
    end

    // A candidate is blocked by any active level at or above its own.
    assign blocked = |(isr_q >> cand_lvl_i);
    assign issue_o = cand_vld_i && !blocked && !hold_q && !reti_i && !ack_i;
    assign isr_o   = isr_q;

endmodule

// File: rtl/ipc_ctrl.sv
// Top of the interrupt priority controller. Combines source flags into
// slots, arbitrates them, gates against the in-service state, and registers
// the request strobe, level, number and vector (one cycle of detection).
// Assumes single-cycle ack/reti/instr_done pulses from the CPU.
module ipc_ctrl
    import ipc_pkg::*;
#(
    parameter int          NUM_TMR    = 4,
    parameter int          GRP_W      = 5,
    parameter int          PORT_NUM   = 12,
    parameter int          GRP_NUM    = 14,
    parameter int          DBG_NUM    = 15,
    parameter int          NUM_W      = 4,
    parameter int          VEC_W      = 16,
    parameter int          VEC_OFS    = 3,
    parameter int          VEC_STRIDE = 8,
    parameter logic [15:0] ALT_BASE   = 16'h4000,
    parameter int          DW         = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_TMR:0]   src_flag_i,
    input  logic [GRP_W-1:0]   grp_flag_i,
    input  logic               dbg_req_i,
    input  logic               reg_we_i,
    input  logic               reg_addr_i,
    input  logic [DW-1:0]      reg_wdata_i,
    output logic [DW-1:0]      reg_rdata_o,
    input  logic               vec_base_sel_i,
    input  logic               ack_i,
    input  logic               reti_i,
    input  logic               instr_done_i,
    output logic               irq_req_o,
    output logic [1:0]         irq_level_o,
    output logic [NUM_W-1:0]   irq_num_o,
    output logic [VEC_W-1:0]   irq_vec_o
);

    localparam int NSLOT = NUM_TMR + 2;

    logic [NSLOT-1:0] pend_w;
    logic [NSLOT-1:0] en_w;
    logic [NSLOT-1:0] prio_w;
    logic             glb_w;
    logic             win_vld;
    lvl_t             win_lvl;
    logic [NUM_W-1:0] win_num;
    logic             issue_w;
    logic [2:0]       isr_w;
    logic [VEC_W-1:0] vec_d;

    logic             req_q;
    lvl_t             lvl_q;
    logic [NUM_W-1:0] num_q;
    logic [VEC_W-1:0] vec_q;

    assign pend_w = {|grp_flag_i, src_flag_i};

    ipc_regs #(.DW(DW), .NSLOT(NSLOT)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .rdata_o (reg_rdata_o),
        .en_o    (en_w),
        .glb_o   (glb_w),
        .prio_o  (prio_w)
    );

    ipc_arbiter #(
        .NSLOT(NSLOT), .NUM_TMR(NUM_TMR), .PORT_NUM(PORT_NUM),
        .GRP_NUM(GRP_NUM), .DBG_NUM(DBG_NUM), .NUM_W(NUM_W)
    ) u_arb (
        .pend_i    (pend_w),
        .en_i      (en_w),
        .glb_i     (glb_w),
        .prio_i    (prio_w),
        .dbg_i     (dbg_req_i),
        .win_vld_o (win_vld),
        .win_lvl_o (win_lvl),
        .win_num_o (win_num)
    );

    ipc_service u_svc (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_i       (ack_i),
        .reti_i      (reti_i),
        .done_i      (instr_done_i),
        .req_i       (req_q),
        .grant_lvl_i (lvl_q),
        .cand_vld_i  (win_vld),
        .cand_lvl_i  (win_lvl),
        .issue_o     (issue_w),
        .isr_o       (isr_w)
    );

    // Vector address from the winning number and the selected table.
    always_comb begin
        vec_d = VEC_W'(VEC_OFS) + VEC_W'(VEC_STRIDE) * VEC_W'(win_num);
        if (vec_base_sel_i)
            vec_d = vec_d + VEC_W'(ALT_BASE);
    end

    // Output register: one cycle from detection to strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            lvl_q <= LVL_LO;
            num_q <= '0;
            vec_q <= '0;
        end else begin
            req_q <= issue_w;
            if (issue_w) begin
                lvl_q <= win_lvl;
                num_q <= win_num;
                vec_q <= vec_d;
            end
        end
    end

    assign irq_req_o   = req_q;
    assign irq_level_o = lvl_q;
    assign irq_num_o   = num_q;
    assign irq_vec_o   = vec_q;

endmodule

// File: rtl/ipc_ctrl_chk.sv
// Property checker for ipc_ctrl, attached through bind. It observes the
// ports plus the global enable and in-service bits.
module ipc_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ack_i,
    input logic        reti_i,
    input logic        irq_req_o,
    input logic [1:0]  irq_level_o,
    input logic [15:0] irq_vec_o,
    input logic        glb,
    input logic [2:0]  isr
);

    // R1: an ordinary-level request needs the global enable of the decode cycle
    a_r1_global_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o && irq_level_o != 2'd2) |-> $past(glb));

    // R2: no level code above the debug level is ever presented
    a_r2_level_range: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> irq_level_o != 2'd3);

    // R6: vector addresses lie on the offset-3, stride-8 grid
    a_r6_vec_grid: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> irq_vec_o[2:0] == 3'b011);

    // R7: a presented request is strictly above every active level
    a_r7_above_active: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (isr >> irq_level_o) == 3'b000);

    // R8: no strobe right after a return
    a_r8_no_req_after_ret: assert property (@(posedge clk) disable iff (!rst_n)
        reti_i |=> !irq_req_o);

    // R9: acknowledge drops the strobe and marks the level in service
    a_r9_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_req_o) |=> !irq_req_o);

    a_r9_ack_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_req_o && !reti_i) |=> ((isr >> $past(irq_level_o)) & 3'b001) == 3'b001);

endmodule

bind ipc_ctrl ipc_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack_i       (ack_i),
    .reti_i      (reti_i),
    .irq_req_o   (irq_req_o),
    .irq_level_o (irq_level_o),
    .irq_vec_o   (irq_vec_o),
    .glb         (glb_w),
    .isr         (isr_w)
);

// File: tb/ipc_ctrl_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: stimulus pushes the expected output of the next clock
// edge; a monitor pops and compares 2 ns after each rising edge.
module ipc_ctrl_tb;

    typedef struct {
        string      tag;
        bit         req;
        logic [3:0] num;
        logic [1:0] lvl;
        bit         base;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_flag = '0;
    logic [4:0]  grp_flag = '0;
    logic        dbg = 1'b0;
    logic        we = 1'b0;
    logic        addr = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        base_sel = 1'b0;
    logic        ack = 1'b0;
    logic        reti = 1'b0;
    logic        done = 1'b0;
    logic        irq_req;
    logic [1:0]  irq_lvl;
    logic [3:0]  irq_num;
    logic [15:0] irq_vec;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    ipc_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_flag_i(src_flag), .grp_flag_i(grp_flag),
        .dbg_req_i(dbg), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .vec_base_sel_i(base_sel), .ack_i(ack),
        .reti_i(reti), .instr_done_i(done), .irq_req_o(irq_req),
        .irq_level_o(irq_lvl), .irq_num_o(irq_num), .irq_vec_o(irq_vec)
    );

    task automatic nb();
        @(negedge clk);
    endtask

    // Expectation for the output seen just after the next rising edge.
    task automatic ex(string tag, bit r, int n, int l);
        exp_t e;
        e.tag = tag; e.req = r; e.num = 4'(n); e.lvl = 2'(l); e.base = base_sel;
        sb.push_back(e);
    endtask

    task automatic wr(bit a, logic [7:0] d);
        nb(); we = 1'b1; addr = a; wdata = d;
        nb(); we = 1'b0;
    endtask

    task automatic rdchk(string tag, bit a, logic [7:0] e);
        addr = a;
        #1;
        n_tests++;
        if (rdata !== e) begin
            n_fail++;
            $display("FAIL %s: reg %0d read %02h expected %02h", tag, a, rdata, e);
        end
    endtask

    // Monitor: compare each queued expectation with the outputs.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                logic [15:0] ev;
                e = sb.pop_front();
                n_tests++;
                ev = (e.base ? 16'h4000 : 16'h0000) + 16'd3 + 16'd8 * 16'(e.num);
                if (irq_req !== e.req) begin
                    n_fail++;
                    $display("FAIL %s: req %0b expected %0b", e.tag, irq_req, e.req);
                end else if (e.req && (irq_num !== e.num || irq_lvl !== e.lvl || irq_vec !== ev)) begin
                    n_fail++;
                    $display("FAIL %s: num/lvl/vec %0d/%0d/%04h expected %0d/%0d/%04h",
                             e.tag, irq_num, irq_lvl, irq_vec, e.num, e.lvl, ev);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) nb();
        rst_n = 1'b1;
        ex("R9 reset", 0, 0, 0);
        rdchk("R10 reset enable", 1'b0, 8'h00);
        rdchk("R10 reset level", 1'b1, 8'h00);

        // R10: unused bits read as zero
        wr(1'b1, 8'hFF);
        rdchk("R10 level readback", 1'b1, 8'h3F);
        wr(1'b1, 8'h00);

        // R1: slot enable without global enable is masked
        wr(1'b0, 8'h01);
        src_flag = 5'b00001; ex("R1 no global", 0, 0, 0);
        nb(); ex("R1 no global", 0, 0, 0);
        rdchk("R10 enable readback", 1'b0, 8'h01);
        wr(1'b0, 8'h81);
        ex("R1 both enables", 1, 1, 0);

        // R6: one-cycle detection latency
        nb(); src_flag = 5'b00000; ex("R6 idle", 0, 0, 0);
        nb(); src_flag = 5'b00001; ex("R6 latency", 1, 1, 0);

        // R4: natural order on one level
        wr(1'b0, 8'hBF);
        nb(); src_flag = 5'b10100; ex("R4 timer2 over port", 1, 3, 0);
        nb(); src_flag = 5'b10101; ex("R4 timer0 first", 1, 1, 0);
        nb(); src_flag = 5'b00000; grp_flag = 5'b01000; ex("R5 group member", 1, 14, 0);

        // R3: level bit lifts the port over timer 0
        wr(1'b1, 8'h10);
        nb(); grp_flag = 5'b00000; src_flag = 5'b10001; ex("R3 port level1", 1, 12, 1);

        // R5: shared group level bit
        wr(1'b1, 8'h20);
        nb(); src_flag = 5'b00000; grp_flag = 5'b00001; ex("R5 group level1", 1, 14, 1);
        nb(); src_flag = 5'b00001; ex("R5 group over timer0", 1, 14, 1);

        // R11: alternate vector table
        nb(); base_sel = 1'b1; ex("R11 alt base", 1, 14, 1);

        // R1: global enable cleared masks everything ordinary
        wr(1'b0, 8'h3F);
        nb(); base_sel = 1'b0; ex("R1 global off", 0, 0, 0);

        // R2: debug bypasses enables
        nb(); dbg = 1'b1; ex("R2 debug", 1, 15, 2);
        nb(); dbg = 1'b0; ex("R1 global off", 0, 0, 0);

        // R7 / R9: nesting
        wr(1'b1, 8'h10);
        wr(1'b0, 8'hBF);
        nb(); grp_flag = 5'b00000; src_flag = 5'b00001; ex("R7 timer0", 1, 1, 0);
        nb(); ack = 1'b1; ex("R9 ack drops", 0, 0, 0);
        nb(); ack = 1'b0; ex("R7 equal blocked", 0, 0, 0);
        nb(); ex("R7 equal blocked", 0, 0, 0);
        nb(); src_flag = 5'b10001; ex("R7 preempt", 1, 12, 1);
        nb(); ack = 1'b1; ex("R9 ack drops", 0, 0, 0);
        nb(); ack = 1'b0; ex("R7 level1 blocked", 0, 0, 0);
        nb(); dbg = 1'b1; ex("R7 debug preempt", 1, 15, 2);
        nb(); dbg = 1'b0; ex("R7 level1 blocked", 0, 0, 0);

        // R8: return then one instruction
        nb(); reti = 1'b1; ex("R8 at return", 0, 0, 0);
        nb(); reti = 1'b0; ex("R8 hold", 0, 0, 0);
        nb(); ex("R8 hold", 0, 0, 0);
        nb(); done = 1'b1; ex("R8 instr edge", 0, 0, 0);
        nb(); done = 1'b0; ex("R8 after instr", 1, 12, 1);

        // R9: returns clear the top level only
        nb(); ack = 1'b1; ex("R9 ack drops", 0, 0, 0);
        nb(); ack = 1'b0; src_flag = 5'b00001; ex("R9 level1 active", 0, 0, 0);
        nb(); reti = 1'b1; ex("R8 at return", 0, 0, 0);
        nb(); reti = 1'b0; done = 1'b1; ex("R8 instr edge", 0, 0, 0);
        nb(); done = 1'b0; ex("R9 level0 still active", 0, 0, 0);
        nb(); reti = 1'b1; ex("R8 at return", 0, 0, 0);
        nb(); reti = 1'b0; done = 1'b1; ex("R8 instr edge", 0, 0, 0);
        nb(); done = 1'b0; ex("R9 all clear", 1, 1, 0);

        while (sb.size() > 0) nb();
        nb();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule